// File: doc/BRIEF.md
# Table-Lookup State Machine

This block is a finite state machine whose next-state and output decoding are not built from gates. Both come from one lookup table. Each clock, the table address is formed from the registered current state code and the sampled input vector. The word read from the table carries the next state code and every output bit. The table is a synchronous-read memory, so the register at its data output is the state register itself. The outputs are sliced straight out of that same registered word.

The table contents are computed at elaboration by a package function. The function walks every address, decodes the state and input fields, and evaluates a small example machine. The example machine has five states: idle, armed, running, holding and done. Inputs and outputs are plain level signals sampled on every clock, with no handshake. The block never stalls and applies no back-pressure. A new lookup happens on every rising edge that is not in reset.

Top module: `rom_fsm_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the registered word is loaded with state code 0 (idle) and all outputs 0. `state_o` reads 0 and `out_o` reads 0 one clock later.
- R2: Table address layout: the current state occupies address bits [4:0], `in_i[0]` drives address bit 5, and `in_i[1]` drives address bit 6. Table word layout: the next state is in bits [4:0], and `out_o[k]` is word bit 5+k.
- R3: In idle (code 0), `in_i[0]`=1 moves to armed (code 1); otherwise the machine stays in idle. All outputs are 0 for both input values.
- R4: In armed (code 1), `out_o[0]` is 1. If `in_i[1]`=1 the machine moves to running (code 2). Otherwise it returns to idle if `in_i[0]`=0, and stays armed if `in_i[0]`=1.
- R5: In running (code 2), `out_o[1]` is 1. If `in_i[1]`=0 the machine moves to holding (code 4). Otherwise it moves to done (code 3) if `in_i[0]`=1, and stays running if `in_i[0]`=0.
- R6: In holding (code 4), `out_o[0]` and `out_o[1]` are both 1. The machine moves to running if `in_i[1]`=1, and to idle otherwise.
- R7: In done (code 3), `out_o[2]` is 1 and `out_o[3]` equals `in_i[1]`. The next state is idle regardless of the inputs.
- R8: An output bit is 0 unless the entry of the current state sets it. Outputs and the state code change exactly one clock after the state/input combination that selected them.
- R9: For any input sequence, `state_o` stays within codes 0 to 4. Every undefined state code has idle as its next state in the table.
- R10: The first rising edge after `rst` falls already performs a lookup from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_i | input | N_IN (2) | Input vector, sampled every rising edge |
| out_o | output | N_OUT (4) | Output vector, taken from the registered table word |
| state_o | output | STATE_W (5) | Current state code, taken from the registered table word |

## Verification
The assertions assume three things. `rst` is high at the first rising edge. `in_i` is stable and known around every rising edge. No other agent alters the table. Under those conditions the state code can only take the five defined values, and each per-state transition holds. The bench holds reset across the opening edges. It changes `in_i` only on falling edges and compares every cycle with an independent per-state reference model. The model covers directed branches on each input bit, a reset in the middle of operation, and a long pseudo-random input walk.

// File: rtl/rom_fsm_pkg.sv
package rom_fsm_pkg;

  // State codes of the example machine.
  localparam int unsigned ST_IDLE = 0;
  localparam int unsigned ST_ARM  = 1;
  localparam int unsigned ST_RUN  = 2;
  localparam int unsigned ST_DONE = 3;
  localparam int unsigned ST_HOLD = 4;
  localparam int unsigned ST_LAST = 4;

  // Table word for one address: next state in the low state_w bits,
  // output k at bit state_w+k. Input k is address bit state_w+k.
  function automatic logic [31:0] fsm_word(int unsigned addr, int unsigned state_w);
    int unsigned st;
    logic        in0;
    logic        in1;
    int unsigned nxt;
    logic [3:0]  o;
    st  = addr & ((32'd1 << state_w) - 1);
    in0 = ((addr >> state_w) & 1) != 0;
    in1 = ((addr >> (state_w + 1)) & 1) != 0;
    o   = 4'b0000;
    nxt = ST_IDLE;
    case (st)
      ST_IDLE: nxt = in0 ? ST_ARM : ST_IDLE;
      ST_ARM: begin
        o[0] = 1'b1;
        if (in1)       nxt = ST_RUN;
        else if (!in0) nxt = ST_IDLE;
        else           nxt = ST_ARM;
      end
      ST_RUN: begin
        o[1] = 1'b1;
        if (!in1)     nxt = ST_HOLD;
        else if (in0) nxt = ST_DONE;
        else          nxt = ST_RUN;
      end
      ST_HOLD: begin
        o[0] = 1'b1;
        o[1] = 1'b1;
        nxt  = in1 ? ST_RUN : ST_IDLE;
      end
      ST_DONE: begin
        o[2] = 1'b1;
        o[3] = in1;
        nxt  = ST_IDLE;
      end
      default: nxt = ST_IDLE;   // undefined codes fall back to idle
    endcase
    return nxt | (32'(o) << state_w);
  endfunction

endpackage

// File: rtl/rom_fsm_addr.sv
module rom_fsm_addr #(
  parameter int unsigned STATE_W = 5,
  parameter int unsigned N_IN    = 2,
  localparam int unsigned ADDR_W = STATE_W + N_IN
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [N_IN-1:0]    in_i,
  output logic [ADDR_W-1:0]  addr_o
);
  // Inputs take the bits above the state field, in index order.
  assign addr_o = {in_i, state_i};
endmodule

// File: rtl/rom_fsm_table.sv
module rom_fsm_table
  import rom_fsm_pkg::*;
#(
  parameter int unsigned STATE_W = 5,
  parameter int unsigned N_IN    = 2,
  parameter int unsigned N_OUT   = 4,
  localparam int unsigned ADDR_W = STATE_W + N_IN,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned WORD_W = STATE_W + N_OUT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] table_w [DEPTH];
  logic [WORD_W-1:0] word_q;

  // One constant word per address, computed at elaboration.
  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign table_w[a] = WORD_W'(fsm_word(a, STATE_W));
  end

  // Synchronous read: this register is the machine's state register.
  always_ff @(posedge clk) begin
    if (rst) word_q <= WORD_W'(ST_IDLE);
    else     word_q <= table_w[addr_i];
  end

  assign word_o = word_q;

  assert_reset_word_R1: assert property (@(posedge clk)
    rst |=> (word_o == WORD_W'(ST_IDLE)));

endmodule

// File: rtl/rom_fsm_engine.sv
module rom_fsm_engine
  import rom_fsm_pkg::*;
#(
  parameter int unsigned STATE_W = 5,
  parameter int unsigned N_IN    = 2,
  parameter int unsigned N_OUT   = 4,
  localparam int unsigned ADDR_W = STATE_W + N_IN,
  localparam int unsigned WORD_W = STATE_W + N_OUT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_IN-1:0]    in_i,
  output logic [N_OUT-1:0]   out_o,
  output logic [STATE_W-1:0] state_o
);
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] word;

  rom_fsm_addr #(.STATE_W(STATE_W), .N_IN(N_IN)) u_addr (
    .state_i (state_o),
    .in_i    (in_i),
    .addr_o  (addr)
  );

  rom_fsm_table #(.STATE_W(STATE_W), .N_IN(N_IN), .N_OUT(N_OUT)) u_table (
    .clk    (clk),
    .rst    (rst),
    .addr_i (addr),
    .word_o (word)
  );

  assign state_o = word[STATE_W-1:0];
  assign out_o   = word[WORD_W-1:STATE_W];

  assert_state_legal_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (state_o <= STATE_W'(ST_LAST)));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == STATE_W'(ST_IDLE) && !in_i[0]) |=>
      (state_o == STATE_W'(ST_IDLE) && out_o == '0));

  assert_arm_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == STATE_W'(ST_ARM)) |=> out_o[0]);

  assert_run_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == STATE_W'(ST_RUN) && !in_i[1]) |=> (state_o == STATE_W'(ST_HOLD)));

  assert_done_return_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == STATE_W'(ST_DONE)) |=>
      (state_o == STATE_W'(ST_IDLE) && out_o[2] && out_o[3] == $past(in_i[1])));

endmodule

// File: tb/rom_fsm_engine_tb.sv
module rom_fsm_engine_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] in_v = 2'b00;
  logic [3:0] out_o;
  logic [4:0] state_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] m_state = 5'd0;

  always #10 clk = ~clk;   // 50 MHz

  rom_fsm_engine u_dut (
    .clk(clk), .rst(rst), .in_i(in_v), .out_o(out_o), .state_o(state_o)
  );

  // Independent reference: {outputs[3:0], next[4:0]}.
  function automatic logic [8:0] ref_word(logic [4:0] s, logic [1:0] v);
    logic [3:0] o;
    logic [4:0] n;
    o = 4'b0; n = 5'd0;
    case (s)
      5'd0: n = v[0] ? 5'd1 : 5'd0;
      5'd1: begin o = 4'b0001; n = v[1] ? 5'd2 : (v[0] ? 5'd1 : 5'd0); end
      5'd2: begin o = 4'b0010; n = !v[1] ? 5'd4 : (v[0] ? 5'd3 : 5'd2); end
      5'd4: begin o = 4'b0011; n = v[1] ? 5'd2 : 5'd0; end
      5'd3: begin o = {v[1], 3'b100}; n = 5'd0; end
      default: n = 5'd0;
    endcase
    return {o, n};
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got out=%b state=%0d, expected out=%b state=%0d",
               req, act[8:5], act[4:0], exp[8:5], exp[4:0]);
    end
  endtask

  // Drive inputs on a falling edge, check one clock later.
  task automatic step(logic [1:0] v, string req);
    logic [8:0] e;
    in_v = v;
    e = ref_word(m_state, v);
    @(negedge clk);
    check(req, {out_o, state_o}, e);
    m_state = e[4:0];
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_v = 2'b11;
    @(negedge clk); @(negedge clk);
    check("R1 reset", {out_o, state_o}, 9'd0);
    @(negedge clk);
    check("R1 reset held", {out_o, state_o}, 9'd0);
    rst = 1'b0; m_state = 5'd0;
  endtask

  task automatic t_idle();
    step(2'b00, "R3 idle stays");
    step(2'b10, "R3 idle ignores in1, R2 bit6");
    step(2'b01, "R10 R2 idle to armed via bit5");
  endtask

  task automatic t_arm();
    step(2'b01, "R4 armed holds");
    step(2'b00, "R4 armed to idle");
    step(2'b01, "R3 to armed");
    step(2'b10, "R4 R2 armed to running via bit6");
  endtask

  task automatic t_run();
    step(2'b10, "R5 running holds");
    step(2'b00, "R5 running to holding");
    step(2'b10, "R6 holding to running");
    step(2'b00, "R5 running to holding");
    step(2'b00, "R6 holding to idle");
  endtask

  task automatic t_done();
    step(2'b01, "R3 to armed");
    step(2'b10, "R4 to running");
    step(2'b11, "R5 running to done");
    step(2'b10, "R7 done out3=1, to idle");
    step(2'b01, "R8 idle outputs clear");
    step(2'b10, "R4 to running");
    step(2'b11, "R5 to done");
    step(2'b01, "R7 done out3=0, to idle");
  endtask

  task automatic t_midreset();
    step(2'b01, "R3 to armed");
    step(2'b10, "R4 to running");
    t_reset();
    step(2'b01, "R10 lookup right after reset");
  endtask

  task automatic t_walk();
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[1:0], "R8 R9 random walk");
      n_tests++;
      if (state_o > 5'd4) begin
        n_fail++;
        $display("FAIL R9: state %0d, expected 0..4", state_o);
      end
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle();
        t_arm();
        t_run();
        t_done();
        t_midreset();
        t_walk();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule